// File: doc/BRIEF.md
# UART Receive Packet Flush Controller

This block sits between a UART receiver and a packet transport. It gathers received bytes into a packet bank. It closes that bank and offers it downstream in either of two cases, whichever comes first. The first case is a full packet. The second is a stretch of line silence after the last character. Silence is measured in microsecond ticks against a per-baud-range timeout table. The table resets to the shorter of a fixed cap and the duration of a few character times at that range's nominal baud. The table can be rewritten entry by entry.

There are two banks. A closed packet waits for the consumer's acknowledge while new bytes fill the other bank. The consumer reads the waiting packet by index and then acknowledges it. A byte that arrives when both banks hold closed packets is dropped and flagged.

Top module: `uart_pkt_flush`

## Requirements
- R1: When the 64th byte of a packet is accepted, that packet is closed. `pkt_valid_o` (if no older packet waits) and a length of 64 are presented from the next cycle.
- R2: A non-empty packet closes on the N-th `us_tick_i` after its last accepted byte. N is the table entry chosen by `rng_sel_i`, sampled at that tick. An entry of 0 acts as 1.
- R3: Every accepted byte restarts the idle count from zero. A tick in the same cycle as an accepted byte is not counted.
- R4: While the filling bank is empty, ticks never close a packet. No empty packet is ever presented.
- R5: After reset, table entries 0..3 hold min(1000, ceil(18,000,000 / baud)) for nominal bauds 300, 9600, 57600 and 921600. That gives 1000, 1000, 313 and 20. A cycle with `cfg_we_i` high replaces entry `cfg_idx_i` with `cfg_tmo_i` from the next cycle.
- R6: `pkt_len_o` gives the byte count of the oldest waiting packet. `pkt_data_o` gives its byte at index `rd_idx_i`, combinationally, with index 0 being the first byte received.
- R7: `pkt_ack_i` while `pkt_valid_o` is high discards the oldest packet. The next waiting packet, if any, is presented from the next cycle. `pkt_ack_i` with no packet waiting has no effect.
- R8: Bytes keep being accepted into the second bank while one packet waits. `buf_full_o` is high exactly while two closed packets wait.
- R9: A byte arriving while `buf_full_o` is high is not stored. `overrun_o` is high for exactly the following cycle.
- R10: After reset, `pkt_valid_o`, `buf_full_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| rng_sel_i | input | 2 | Baud-range index selecting the timeout entry |
| cfg_we_i | input | 1 | Timeout table write enable |
| cfg_idx_i | input | 2 | Timeout table entry to write |
| cfg_tmo_i | input | 11 | New timeout in microsecond ticks |
| pkt_valid_o | output | 1 | A closed packet is waiting |
| pkt_len_o | output | 7 | Byte count of the waiting packet |
| pkt_ack_i | input | 1 | Consumer has taken the waiting packet |
| rd_idx_i | input | 6 | Byte index into the waiting packet |
| pkt_data_o | output | 8 | Byte at `rd_idx_i` of the waiting packet |
| buf_full_o | output | 1 | Both banks hold closed packets |
| overrun_o | output | 1 | A byte was dropped in the previous cycle |

## Verification
The bound checker watches the handshake and flag relations every cycle:
- a presented length is never zero and never above a full packet;
- a waiting packet and its length stay put until acknowledged;
- a full indication implies a waiting packet;
- `overrun_o` follows exactly the cycles in which a byte met a full buffer;
- a packet only appears after a cycle with a byte or a tick.

Only the bench can show the rest:
- the exact tick on which a timeout closes a packet;
- the restart on each byte;
- the reset contents of the timeout table;
- the byte order of a packet;
- that a dropped byte is truly absent.

It does this through directed scenarios plus a behavioural queue model compared on every cycle.

// File: rtl/uart_pkt_pkg.sv
package uart_pkt_pkg;
  localparam int PKT_BYTES  = 64;
  localparam int NUM_BANKS  = 2;
  localparam int NUM_RANGES = 4;
  localparam int TMO_W      = 11;
  localparam int BYTE_W     = 8;
  localparam int TMO_CAP_US = 1000;
  localparam int CHAR_BITS  = 18;
  localparam int IDX_W      = $clog2(PKT_BYTES);
  localparam int LEN_W      = $clog2(PKT_BYTES + 1);
  localparam int RNG_W      = $clog2(NUM_RANGES);
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int PEND_W     = $clog2(NUM_BANKS + 1);

  localparam int unsigned RANGE_BAUD [NUM_RANGES] = '{300, 9600, 57600, 921600};

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [TMO_W-1:0]  tmo_t;
  typedef logic [LEN_W-1:0]  len_t;

  // shorter of the cap and CHAR_BITS bit times, rounded up to whole us
  function automatic tmo_t default_tmo(input int unsigned baud);
    int unsigned t;
    t = (CHAR_BITS * 1000000 + baud - 1) / baud;
    if (t > TMO_CAP_US) t = TMO_CAP_US;
    return tmo_t'(t);
  endfunction
endpackage

// File: rtl/uart_pkt_tmo_table.sv
module uart_pkt_tmo_table
  import uart_pkt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RNG_W-1:0] widx_i,
  input  tmo_t             wval_i,
  input  logic [RNG_W-1:0] sel_i,
  output tmo_t             tmo_o
);
  tmo_t tbl_q [NUM_RANGES];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tbl_q[g] <= default_tmo(RANGE_BAUD[g]);
      else if (we_i && widx_i == RNG_W'(g))       tbl_q[g] <= wval_i;
    end
  end

  assign tmo_o = tbl_q[sel_i];
endmodule

// File: rtl/uart_pkt_idle_timer.sv
module uart_pkt_idle_timer
  import uart_pkt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic tick_i,
  input  tmo_t limit_i,
  output logic expire_o
);
  tmo_t             cnt_q;
  tmo_t             lim_eff;
  logic [TMO_W:0]   cnt_inc;

  assign lim_eff  = (limit_i == '0) ? tmo_t'(1) : limit_i;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = run_i && tick_i && (cnt_inc >= {1'b0, lim_eff});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (restart_i || !run_i || expire_o) cnt_q <= '0;
    else if (tick_i)                       cnt_q <= cnt_inc[TMO_W-1:0];
  end
endmodule

// File: rtl/uart_pkt_bank_store.sv
module uart_pkt_bank_store
  import uart_pkt_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wbank_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  byte_t             wdata_i,
  input  logic [BANK_W-1:0] rbank_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output byte_t             rdata_o
);
  byte_t mem_q [NUM_BANKS][PKT_BYTES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wbank_i][waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[rbank_i][raddr_i];
endmodule

// File: rtl/uart_pkt_flush.sv
module uart_pkt_flush
  import uart_pkt_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_valid_i,
  input  logic [7:0]               rx_data_i,
  input  logic                     us_tick_i,
  input  logic [RNG_W-1:0]         rng_sel_i,
  input  logic                     cfg_we_i,
  input  logic [RNG_W-1:0]         cfg_idx_i,
  input  logic [TMO_W-1:0]         cfg_tmo_i,
  output logic                     pkt_valid_o,
  output logic [LEN_W-1:0]         pkt_len_o,
  input  logic                     pkt_ack_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [7:0]               pkt_data_o,
  output logic                     buf_full_o,
  output logic                     overrun_o
);
  logic [BANK_W-1:0] wr_bank_q, rd_bank_q;
  len_t              wr_cnt_q;
  logic [PEND_W-1:0] pend_q;
  len_t              len_q [NUM_BANKS];
  logic              ovr_q;

  logic has_room, accept, fill_last, tmo_close, close_pkt, pop;
  len_t close_len;
  tmo_t cur_tmo;

  assign has_room  = pend_q != PEND_W'(NUM_BANKS);
  assign accept    = rx_valid_i && has_room;
  assign fill_last = accept && (wr_cnt_q == len_t'(PKT_BYTES - 1));
  assign close_pkt = fill_last || tmo_close;
  assign close_len = fill_last ? len_t'(PKT_BYTES) : wr_cnt_q;
  assign pop       = pkt_ack_i && (pend_q != '0);

  uart_pkt_tmo_table u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .widx_i (cfg_idx_i),
    .wval_i (cfg_tmo_i),
    .sel_i  (rng_sel_i),
    .tmo_o  (cur_tmo)
  );

  uart_pkt_idle_timer u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .run_i     ((wr_cnt_q != '0) && !accept),
    .tick_i    (us_tick_i),
    .limit_i   (cur_tmo),
    .expire_o  (tmo_close)
  );

  uart_pkt_bank_store u_store (
    .clk_i   (clk_i),
    .we_i    (accept),
    .wbank_i (wr_bank_q),
    .waddr_i (wr_cnt_q[IDX_W-1:0]),
    .wdata_i (rx_data_i),
    .rbank_i (rd_bank_q),
    .raddr_i (rd_idx_i),
    .rdata_o (pkt_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_q <= '0;
      rd_bank_q <= '0;
      wr_cnt_q  <= '0;
      pend_q    <= '0;
      ovr_q     <= 1'b0;
    end else begin
      ovr_q <= rx_valid_i && !has_room;
      if (close_pkt) begin
        wr_bank_q <= wr_bank_q + 1'b1;
        wr_cnt_q  <= '0;
      end else if (accept) begin
        wr_cnt_q  <= wr_cnt_q + 1'b1;
      end
      if (pop) rd_bank_q <= rd_bank_q + 1'b1;
      pend_q <= pend_q + PEND_W'(close_pkt) - PEND_W'(pop);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_len
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      len_q[b] <= '0;
      else if (close_pkt && wr_bank_q == BANK_W'(b))    len_q[b] <= close_len;
    end
  end

  assign pkt_valid_o = pend_q != '0;
  assign pkt_len_o   = len_q[rd_bank_q];
  assign buf_full_o  = !has_room;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/uart_pkt_flush_chk.sv
module uart_pkt_flush_chk
  import uart_pkt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_valid_i,
  input logic             us_tick_i,
  input logic             pkt_ack_i,
  input logic             pkt_valid_o,
  input logic [LEN_W-1:0] pkt_len_o,
  input logic             buf_full_o,
  input logic             overrun_o
);
  AST_LEN_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_len_o != '0 && pkt_len_o <= LEN_W'(PKT_BYTES))); // R1
  AST_PKT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ack_i) |=> (pkt_valid_o && $stable(pkt_len_o))); // R7
  AST_FULL_HAS_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_o |-> pkt_valid_o); // R8
  AST_OVR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(rx_valid_i && buf_full_o)); // R9
  AST_OVR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && buf_full_o) |=> overrun_o); // R9
  AST_NO_SPONTANEOUS_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_valid_o) |-> $past(rx_valid_i || us_tick_i)); // R4
endmodule

bind uart_pkt_flush uart_pkt_flush_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .us_tick_i   (us_tick_i),
  .pkt_ack_i   (pkt_ack_i),
  .pkt_valid_o (pkt_valid_o),
  .pkt_len_o   (pkt_len_o),
  .buf_full_o  (buf_full_o),
  .overrun_o   (overrun_o)
);

// File: tb/uart_pkt_flush_tb.sv
module uart_pkt_flush_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tick = 1'b0;
  logic [1:0]  rng_sel = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [10:0] cfg_tmo = '0;
  logic        ack = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic        pkt_valid, buf_full, overrun;
  logic [6:0]  pkt_len;
  logic [7:0]  pkt_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uart_pkt_flush u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .us_tick_i(tick), .rng_sel_i(rng_sel), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_tmo_i(cfg_tmo), .pkt_valid_o(pkt_valid), .pkt_len_o(pkt_len),
    .pkt_ack_i(ack), .rd_idx_i(rd_idx), .pkt_data_o(pkt_data),
    .buf_full_o(buf_full), .overrun_o(overrun)
  );

  // reference model
  logic [7:0] cur_q[$];
  logic [7:0] pend_b[$];
  int         pend_l[$];
  int         idle_m = 0;
  bit         ovr_m = 0;
  int         tbl_m [4];
  int         baud_m [4] = '{300, 9600, 57600, 921600};

  initial begin
    for (int i = 0; i < 4; i++) begin
      int t;
      t = (18000000 + baud_m[i] - 1) / baud_m[i];
      tbl_m[i] = (t < 1000) ? t : 1000;
    end
  end

  task automatic close_model();
    foreach (cur_q[k]) pend_b.push_back(cur_q[k]);
    pend_l.push_back(cur_q.size());
    cur_q.delete();
    idle_m = 0;
  endtask

  always @(posedge clk) begin
    int  lim;
    bit  room;
    if (rst_n) begin
      lim  = (tbl_m[rng_sel] == 0) ? 1 : tbl_m[rng_sel];
      room = pend_l.size() < 2;
      if (ack && pend_l.size() > 0) begin
        for (int k = 0; k < pend_l[0]; k++) void'(pend_b.pop_front());
        void'(pend_l.pop_front());
      end
      ovr_m = 0;
      if (rx_valid) begin
        if (room) begin
          cur_q.push_back(rx_data);
          idle_m = 0;
          if (cur_q.size() == 64) close_model();
        end else ovr_m = 1;
      end else if (tick && cur_q.size() > 0) begin
        idle_m++;
        if (idle_m >= lim) close_model();
      end
      if (cfg_we) tbl_m[cfg_idx] = int'(cfg_tmo);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R4", "pkt_valid", int'(pkt_valid), int'(pend_l.size() > 0));
      chk("R8", "buf_full", int'(buf_full), int'(pend_l.size() == 2));
      chk("R9", "overrun", int'(overrun), int'(ovr_m));
      if (pend_l.size() > 0) begin
        chk("R6", "pkt_len", int'(pkt_len), pend_l[0]);
        if (int'(rd_idx) < pend_l[0]) chk("R6", "pkt_data", int'(pkt_data), int'(pend_b[rd_idx]));
      end
    end
  end

  task automatic cyc(bit rv, logic [7:0] d, bit tk, bit ak);
    rx_valid = rv; rx_data = d; tick = tk; ack = ak;
    @(negedge clk);
    rx_valid = 1'b0; tick = 1'b0; ack = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset valid", int'(pkt_valid), 0);
    chk("R10", "reset full", int'(buf_full), 0);
    chk("R10", "reset overrun", int'(overrun), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: ticks on an empty buffer
    rng_sel = 2'd3;
    ticks(30);
    chk("R4", "no empty packet", int'(pkt_valid), 0);

    // R2: partial packet closes on the 20th tick (entry 3)
    cyc(1, 8'hA1, 0, 0);
    ticks(19);
    chk("R2", "before timeout", int'(pkt_valid), 0);
    ticks(1);
    chk("R2", "at timeout", int'(pkt_valid), 1);
    chk("R2", "timeout len", int'(pkt_len), 1);
    chk("R6", "first byte", int'(pkt_data), 'hA1);
    cyc(0, 8'h00, 0, 1);
    chk("R7", "ack pops", int'(pkt_valid), 0);

    // R3: byte restarts idle count; tick with byte not counted
    cyc(1, 8'h10, 0, 0);
    ticks(15);
    cyc(1, 8'h11, 1, 0);
    ticks(19);
    chk("R3", "restart", int'(pkt_valid), 0);
    ticks(1);
    chk("R3", "after restart", int'(pkt_valid), 1);
    chk("R3", "len", int'(pkt_len), 2);
    cyc(0, 8'h00, 0, 1);

    // R1/R6: full packet
    for (int i = 0; i < 64; i++) cyc(1, 8'(i * 3 + 1), 0, 0);
    chk("R1", "full valid", int'(pkt_valid), 1);
    chk("R1", "full len", int'(pkt_len), 64);
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      #1;
      chk("R6", "byte order", int'(pkt_data), (i * 3 + 1) & 'hFF);
    end
    rd_idx = '0;
    @(negedge clk);

    // R8: second bank fills while first waits
    for (int i = 0; i < 10; i++) cyc(1, 8'(8'h50 + i), 0, 0);
    chk("R8", "not yet full", int'(buf_full), 0);
    ticks(20);
    chk("R8", "both banks", int'(buf_full), 1);
    chk("R8", "head kept", int'(pkt_len), 64);
    // R9: overrun
    cyc(1, 8'hEE, 0, 0);
    chk("R9", "overrun pulse", int'(overrun), 1);
    cyc(0, 8'h00, 0, 0);
    chk("R9", "overrun single", int'(overrun), 0);
    cyc(0, 8'h00, 0, 1);
    chk("R7", "next packet", int'(pkt_len), 10);
    chk("R9", "dropped byte absent", int'(pkt_data), 'h50);
    chk("R8", "full cleared", int'(buf_full), 0);
    cyc(0, 8'h00, 0, 1);
    chk("R7", "drained", int'(pkt_valid), 0);
    cyc(0, 8'h00, 0, 1);
    chk("R7", "ack when empty", int'(pkt_valid), 0);
    cyc(1, 8'h11, 0, 0);
    ticks(20);
    chk("R7", "after empty ack len", int'(pkt_len), 1);
    chk("R9", "after overrun data", int'(pkt_data), 'h11);
    cyc(0, 8'h00, 0, 1);

    // R5: reset table values
    rng_sel = 2'd2;
    cyc(1, 8'h22, 0, 0);
    ticks(312);
    chk("R5", "entry2 early", int'(pkt_valid), 0);
    ticks(1);
    chk("R5", "entry2 313", int'(pkt_valid), 1);
    cyc(0, 8'h00, 0, 1);
    rng_sel = 2'd0;
    cyc(1, 8'h33, 0, 0);
    ticks(999);
    chk("R5", "entry0 early", int'(pkt_valid), 0);
    ticks(1);
    chk("R5", "entry0 1000", int'(pkt_valid), 1);
    cyc(0, 8'h00, 0, 1);

    // R5/R2: rewrite entry 1 to zero -> one tick
    cfg_we = 1'b1; cfg_idx = 2'd1; cfg_tmo = 11'd0;
    cyc(0, 8'h00, 0, 0);
    rng_sel = 2'd1;
    cyc(1, 8'h44, 0, 0);
    ticks(1);
    chk("R2", "zero acts as one", int'(pkt_valid), 1);
    cyc(0, 8'h00, 0, 1);

    // random traffic against the model
    for (int i = 0; i < 4; i++) begin
      cfg_we = 1'b1; cfg_idx = 2'(i); cfg_tmo = 11'(3 + i);
      cyc(0, 8'h00, 0, 0);
    end
    for (int i = 0; i < 4000; i++) begin
      rng_sel = 2'($urandom_range(0, 3));
      rd_idx  = 6'($urandom_range(0, 63));
      cyc(($urandom_range(0, 99) < 45), 8'($urandom), ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 9) == 0));
    end
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule